// File: doc/BRIEF.md
# Radio Core Power-State Sequencer

This block steps the digital core of a radio transceiver through its power states. It starts in an unpowered state. After supply-good it turns on the crystal and the external enable line, and it keeps the core in reset until a hold count, clocked by the low-power oscillator, has expired. It then releases the core into an initialisation state, where it turns on the PLL by itself and waits for lock. Once the PLL locks, the block moves to the fully running state.

From the running state the host can put the core into one of two low-power states. The shallow one wakes on a sleep timer, on the wake pin or on SPI chip-select. The deep one wakes only on the pin or on chip-select. Every wake re-runs the crystal hold count before the core is released again.

The analog comparator, the oscillators and the PLL are outside the block. They appear as plain inputs: `pwr_good`, `lp_tick` (one system-clock pulse per low-power oscillator period) and `pll_locked`. All logic runs on the single clock `clk` with a synchronous active-high reset.

Top module: `radio_pwr_seq`

## Requirements
- R1: During and after reset the state is OFF and `core_rst`=1, with `ext_en`, `xtal_en`, `pll_en`, `retain` and `spi_slow` all 0. The `state_code` output encodes the states as OFF=0, WAKEUP=1, INIT=2, IDLE=3, SLEEP=4, DEEPSLEEP=5.
- R2: With `pwr_good`=1 in OFF, the next cycle is WAKEUP, with `ext_en`=1, `xtal_en`=1 and `core_rst` still 1.
- R3: WAKEUP stays until `HOLD_TICKS` pulses of `lp_tick` have been counted inside it. It moves to INIT on the clock edge after the edge that takes in the last pulse.
- R4: In INIT, `core_rst`=0, `pll_en`=1 and `spi_slow`=1, and the state holds while `pll_locked`=0. When `pll_locked`=1 the next state is IDLE, where `spi_slow`=0.
- R5: In IDLE, `pll_locked`=0 returns the block to INIT on the next cycle. This takes priority over sleep commands.
- R6: In IDLE, `cmd_deep`=1 enters DEEPSLEEP and `cmd_sleep`=1 enters SLEEP, and `cmd_deep` wins when both are set. In any other state both commands have no effect.
- R7: In SLEEP and DEEPSLEEP, `xtal_en`, `pll_en` and `ext_en` are 0, while `core_rst` and `retain` are 1.
- R8: On entry to SLEEP the sleep timer loads the reload register. The timer decrements on each `lp_tick`. The cycle after it reaches zero the state becomes WAKEUP.
- R9: In SLEEP, `wake_pin`=1 or `spi_cs_n`=0 moves to WAKEUP on the next cycle, before the timer runs out.
- R10: In DEEPSLEEP, only `wake_pin`=1 or `spi_cs_n`=0 leaves the state, going to WAKEUP. Pulses on `lp_tick` have no effect there.
- R11: After any wake, WAKEUP counts the full `HOLD_TICKS` again before INIT.
- R12: With `pwr_good`=0, every state goes to OFF on the next cycle, and the outputs take their R1 values.
- R13: The reload register resets to `SLEEP_TICKS_DEFAULT`. A cycle with `cfg_we`=1 stores `cfg_val` into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply above power-on threshold |
| lp_tick | input | 1 | One-cycle pulse per low-power oscillator period |
| pll_locked | input | 1 | PLL lock indication |
| wake_pin | input | 1 | External wake request, active high |
| spi_cs_n | input | 1 | SPI chip-select, active low |
| cmd_sleep | input | 1 | Host request to enter SLEEP |
| cmd_deep | input | 1 | Host request to enter DEEPSLEEP |
| cfg_we | input | 1 | Write strobe for the sleep reload register |
| cfg_val | input | TMR_W | Sleep reload value in `lp_tick` periods |
| ext_en | output | 1 | External device enable pin |
| xtal_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| core_rst | output | 1 | Digital core reset, active high |
| retain | output | 1 | Configuration retention active |
| spi_slow | output | 1 | SPI limited to slow clock rate |
| state_code | output | 3 | Current power state code |

## Verification
The hardest case to reach from the ports is telling the wake sources apart. A stray timer wake out of DEEPSLEEP would look just like a legitimate pin wake, unless the bench pulses `lp_tick` far beyond the reload value while both pins stay idle and confirms the state has not moved. The bench also holds the pins quiet in SLEEP and counts ticks edge by edge, so that a wake one tick early or late shows up as a state mismatch. The first SLEEP entry runs before any register write, which exposes the reset reload value. A later write with a different value then shows that the timer loads the register contents.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_WAKE = 3'd1,
    ST_INIT = 3'd2,
    ST_IDLE = 3'd3,
    ST_NAP  = 3'd4,
    ST_DEEP = 3'd5
  } pstate_e;

  typedef struct packed {
    logic ext_en;
    logic xtal_en;
    logic pll_en;
    logic core_rst;
    logic retain;
    logic spi_slow;
  } pctl_t;

  function automatic pctl_t ctl_of(pstate_e s);
    pctl_t c;
    c = '{ext_en: 1'b0, xtal_en: 1'b0, pll_en: 1'b0,
          core_rst: 1'b1, retain: 1'b0, spi_slow: 1'b0};
    case (s)
      ST_WAKE: begin
        c.ext_en  = 1'b1;
        c.xtal_en = 1'b1;
      end
      ST_INIT: begin
        c.ext_en   = 1'b1;
        c.xtal_en  = 1'b1;
        c.pll_en   = 1'b1;
        c.core_rst = 1'b0;
        c.spi_slow = 1'b1;
      end
      ST_IDLE: begin
        c.ext_en   = 1'b1;
        c.xtal_en  = 1'b1;
        c.pll_en   = 1'b1;
        c.core_rst = 1'b0;
      end
      ST_NAP, ST_DEEP: begin
        c.retain = 1'b1;
      end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pwrseq_hold_cnt.sv
module pwrseq_hold_cnt #(
  parameter int HOLD_TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick && cnt != LIMIT) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = (cnt == LIMIT);

  // R3: the count never runs past the hold limit
  p_hold_bounded_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);

  // R3: a tick outside the limit advances the count by exactly one
  p_hold_step_r3: assert property (@(posedge clk) disable iff (rst)
    (run && tick && cnt != LIMIT) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/pwrseq_nap_timer.sv
module pwrseq_nap_timer #(
  parameter int TMR_W               = 16,
  parameter int SLEEP_TICKS_DEFAULT = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [TMR_W-1:0] cfg_val,
  input  logic             load,
  input  logic             run,
  input  logic             tick,
  output logic             expired
);
  localparam logic [TMR_W-1:0] RELOAD_RST = TMR_W'(SLEEP_TICKS_DEFAULT);

  logic [TMR_W-1:0] reload_q;
  logic [TMR_W-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= RELOAD_RST;
    end else if (cfg_we) begin
      reload_q <= cfg_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr <= '0;
    end else if (load) begin
      tmr <= reload_q;
    end else if (run && tick && tmr != '0) begin
      tmr <= tmr - 1'b1;
    end
  end

  assign expired = (tmr == '0);

  // R8: an empty timer stays empty until reloaded
  p_timer_holds_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && tmr == '0) |=> (tmr == '0));

  // R8: each tick while running removes exactly one period
  p_timer_step_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && run && tick && tmr != '0) |=> (tmr == $past(tmr) - 1'b1));

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    pwr_good,
  input  logic    hold_done,
  input  logic    pll_locked,
  input  logic    wake_pin,
  input  logic    spi_cs_n,
  input  logic    cmd_sleep,
  input  logic    cmd_deep,
  input  logic    nap_expired,
  output pstate_e state,
  output pstate_e state_nxt
);
  logic pin_wake;
  assign pin_wake = wake_pin || !spi_cs_n;

  always_comb begin
    state_nxt = state;
    if (!pwr_good) begin
      state_nxt = ST_OFF;
    end else begin
      case (state)
        ST_OFF:  state_nxt = ST_WAKE;
        ST_WAKE: if (hold_done) state_nxt = ST_INIT;
        ST_INIT: if (pll_locked) state_nxt = ST_IDLE;
        ST_IDLE: begin
          if (!pll_locked)    state_nxt = ST_INIT;
          else if (cmd_deep)  state_nxt = ST_DEEP;
          else if (cmd_sleep) state_nxt = ST_NAP;
        end
        ST_NAP:  if (pin_wake || nap_expired) state_nxt = ST_WAKE;
        ST_DEEP: if (pin_wake) state_nxt = ST_WAKE;
        default: state_nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_OFF;
    else     state <= state_nxt;
  end

  // R12: loss of supply forces OFF from any state
  p_off_on_powerloss_r12: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> (state == ST_OFF));

  // R4: INIT is held while the PLL is unlocked
  p_init_waits_lock_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_INIT && pwr_good && !pll_locked) |=> (state == ST_INIT));

  // R10: deep sleep is left only through a pin
  p_deep_pin_only_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DEEP && pwr_good && !wake_pin && spi_cs_n) |=> (state == ST_DEEP));

  // R6: sleep states are entered only from IDLE
  p_sleep_from_idle_r6: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_NAP || state == ST_DEEP) && $past(state) != state)
      |-> ($past(state) == ST_IDLE));

endmodule

// File: rtl/radio_pwr_seq.sv
module radio_pwr_seq
  import pwrseq_pkg::*;
#(
  parameter int HOLD_TICKS          = 16,
  parameter int TMR_W               = 16,
  parameter int SLEEP_TICKS_DEFAULT = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_good,
  input  logic             lp_tick,
  input  logic             pll_locked,
  input  logic             wake_pin,
  input  logic             spi_cs_n,
  input  logic             cmd_sleep,
  input  logic             cmd_deep,
  input  logic             cfg_we,
  input  logic [TMR_W-1:0] cfg_val,
  output logic             ext_en,
  output logic             xtal_en,
  output logic             pll_en,
  output logic             core_rst,
  output logic             retain,
  output logic             spi_slow,
  output logic [2:0]       state_code
);
  pstate_e state, state_nxt;
  logic    hold_done, nap_expired, nap_load;
  pctl_t   ctl_q;

  assign nap_load = (state_nxt == ST_NAP) && (state != ST_NAP);

  pwrseq_hold_cnt #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .run  (state == ST_WAKE),
    .tick (lp_tick),
    .done (hold_done)
  );

  pwrseq_nap_timer #(
    .TMR_W               (TMR_W),
    .SLEEP_TICKS_DEFAULT (SLEEP_TICKS_DEFAULT)
  ) u_nap (
    .clk     (clk),
    .rst     (rst),
    .cfg_we  (cfg_we),
    .cfg_val (cfg_val),
    .load    (nap_load),
    .run     (state == ST_NAP),
    .tick    (lp_tick),
    .expired (nap_expired)
  );

  pwrseq_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .pwr_good    (pwr_good),
    .hold_done   (hold_done),
    .pll_locked  (pll_locked),
    .wake_pin    (wake_pin),
    .spi_cs_n    (spi_cs_n),
    .cmd_sleep   (cmd_sleep),
    .cmd_deep    (cmd_deep),
    .nap_expired (nap_expired),
    .state       (state),
    .state_nxt   (state_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= ctl_of(ST_OFF);
    else     ctl_q <= ctl_of(state_nxt);
  end

  assign ext_en     = ctl_q.ext_en;
  assign xtal_en    = ctl_q.xtal_en;
  assign pll_en     = ctl_q.pll_en;
  assign core_rst   = ctl_q.core_rst;
  assign retain     = ctl_q.retain;
  assign spi_slow   = ctl_q.spi_slow;
  assign state_code = state;

  // R7: clocks off and retention on in both sleep states
  p_sleep_clocks_off_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_NAP || state == ST_DEEP)
      |-> (!xtal_en && !pll_en && !ext_en && core_rst && retain));

  // R4: slow SPI and released core whenever INIT is the state
  p_init_outputs_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_INIT) |-> (spi_slow && !core_rst && pll_en));

  // R2: the crystal is running whenever the core is out of reset
  p_xtal_before_release_r2: assert property (@(posedge clk) disable iff (rst)
    !core_rst |-> (xtal_en && ext_en));

endmodule

// File: tb/radio_pwr_seq_tb.sv
module radio_pwr_seq_tb;
  localparam int HOLD = 4;
  localparam int TW   = 8;
  localparam int DEF  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_good = 0, lp_tick = 0, pll_locked = 0, wake_pin = 0;
  logic spi_cs_n = 1, cmd_sleep = 0, cmd_deep = 0, cfg_we = 0;
  logic [TW-1:0] cfg_val = '0;
  logic ext_en, xtal_en, pll_en, core_rst, retain, spi_slow;
  logic [2:0] state_code;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  radio_pwr_seq #(.HOLD_TICKS(HOLD), .TMR_W(TW), .SLEEP_TICKS_DEFAULT(DEF)) u_dut (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .lp_tick(lp_tick),
    .pll_locked(pll_locked), .wake_pin(wake_pin), .spi_cs_n(spi_cs_n),
    .cmd_sleep(cmd_sleep), .cmd_deep(cmd_deep), .cfg_we(cfg_we), .cfg_val(cfg_val),
    .ext_en(ext_en), .xtal_en(xtal_en), .pll_en(pll_en), .core_rst(core_rst),
    .retain(retain), .spi_slow(spi_slow), .state_code(state_code)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      lp_tick = 1'b1; step(); lp_tick = 1'b0;
    end
  endtask

  // {ext_en, xtal_en, pll_en, core_rst, retain, spi_slow}
  function automatic int outs();
    return {26'd0, ext_en, xtal_en, pll_en, core_rst, retain, spi_slow};
  endfunction

  // from WAKEUP with lock held high: hold count, INIT, IDLE
  task automatic run_to_idle(input string req);
    pulse_tick(HOLD);
    step();
    chk({req, " init after hold"}, state_code, 2);
    step();
    chk({req, " idle"}, state_code, 3);
  endtask

  task automatic t_reset();
    step(2);
    chk("R1 state in reset", state_code, 0);
    chk("R1 outputs in reset", outs(), 6'b000100);
    rst = 1'b0;
    step(2);
    chk("R1 state after reset", state_code, 0);
  endtask

  task automatic t_powerup();
    pwr_good = 1'b1;
    step();
    chk("R2 wakeup state", state_code, 1);
    chk("R2 wakeup outputs", outs(), 6'b110100);
    pulse_tick(HOLD - 1);
    step(3);
    chk("R3 still wakeup short of count", state_code, 1);
    pulse_tick(1);
    chk("R3 wakeup on last tick edge", state_code, 1);
    step();
    chk("R3 init after count", state_code, 2);
    chk("R4 init outputs", outs(), 6'b111001);
    step(5);
    chk("R4 init waits for lock", state_code, 2);
    cmd_sleep = 1'b1; cmd_deep = 1'b1;
    step();
    cmd_sleep = 1'b0; cmd_deep = 1'b0;
    chk("R6 commands ignored in init", state_code, 2);
    pll_locked = 1'b1;
    step();
    chk("R4 idle after lock", state_code, 3);
    chk("R4 idle outputs", outs(), 6'b111000);
  endtask

  task automatic t_lock_loss();
    pll_locked = 1'b0; cmd_sleep = 1'b1;
    step();
    cmd_sleep = 1'b0;
    chk("R5 lock loss back to init", state_code, 2);
    pll_locked = 1'b1;
    step();
    chk("R5 relock to idle", state_code, 3);
  endtask

  task automatic t_nap_timer(input int ticks, input string req);
    cmd_sleep = 1'b1;
    step();
    cmd_sleep = 1'b0;
    chk({req, " sleep entered"}, state_code, 4);
    chk("R7 sleep outputs", outs(), 6'b000110);
    pulse_tick(ticks - 1);
    chk({req, " still asleep one tick short"}, state_code, 4);
    pulse_tick(1);
    chk({req, " asleep on expiry edge"}, state_code, 4);
    step();
    chk({req, " wake on expiry"}, state_code, 1);
    pulse_tick(HOLD - 1);
    step();
    chk("R11 hold re-run after wake", state_code, 1);
    pulse_tick(1);
    step();
    chk("R11 init after repeated hold", state_code, 2);
    step();
    chk("R11 idle again", state_code, 3);
  endtask

  task automatic t_cfg_write();
    cfg_val = 8'd3; cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
    t_nap_timer(3, "R13 written reload");
  endtask

  task automatic t_nap_pins();
    cmd_sleep = 1'b1; step(); cmd_sleep = 1'b0;
    chk("R9 sleep entered", state_code, 4);
    wake_pin = 1'b1; step(); wake_pin = 1'b0;
    chk("R9 wake pin wakes sleep", state_code, 1);
    run_to_idle("R9");
    cmd_sleep = 1'b1; step(); cmd_sleep = 1'b0;
    spi_cs_n = 1'b0; step(); spi_cs_n = 1'b1;
    chk("R9 chip select wakes sleep", state_code, 1);
    run_to_idle("R9");
  endtask

  task automatic t_deep();
    cmd_sleep = 1'b1; cmd_deep = 1'b1;
    step();
    cmd_sleep = 1'b0; cmd_deep = 1'b0;
    chk("R6 deep wins over sleep", state_code, 5);
    chk("R7 deep outputs", outs(), 6'b000110);
    pulse_tick(20);
    step(3);
    chk("R10 ticks ignored in deep", state_code, 5);
    wake_pin = 1'b1; step(); wake_pin = 1'b0;
    chk("R10 wake pin leaves deep", state_code, 1);
    run_to_idle("R10");
    cmd_deep = 1'b1; step(); cmd_deep = 1'b0;
    chk("R6 deep entered", state_code, 5);
    spi_cs_n = 1'b0; step(); spi_cs_n = 1'b1;
    chk("R10 chip select leaves deep", state_code, 1);
    run_to_idle("R10");
  endtask

  task automatic t_power_loss();
    pwr_good = 1'b0;
    step();
    chk("R12 idle to off", state_code, 0);
    chk("R12 outputs off", outs(), 6'b000100);
    pwr_good = 1'b1;
    step();
    chk("R12 restart wakeup", state_code, 1);
    pwr_good = 1'b0;
    step();
    chk("R12 wakeup to off", state_code, 0);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_lock_loss();
    t_nap_timer(DEF, "R8 default reload");
    t_cfg_write();
    t_nap_pins();
    t_deep();
    t_power_loss();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule